// File: doc/BRIEF.md
# Shared System Bus Arbiter with Burst Throttling and Debug Spacing

This block decides which of six agents owns a shared system bus for the next transaction. Four processor lines and two I/O lines raise requests. The arbiter grants one of them at a time. The owner keeps the bus until it strobes `xfer_done`, and at that edge the arbiter picks the next owner. Each request line passes through a short synchronising pipeline before it reaches the arbiter. The I/O lines and the first processor line use a shorter pipeline than the other three processor lines, so the latency from request to grant differs by class.

There are two kinds of ownership. In ordinary ownership, the agent that just finished ranks below every other requester at the next boundary. It wins again back-to-back only if nobody else is asking. In exclusive ownership, an I/O agent that never lowers its request keeps the bus at every boundary, whoever else is waiting. Processor lines are always ordinary, even when they hold their request high.

Two throttles insert empty bus cycles. The first is a fairness throttle: after five consecutive back-to-back transactions by the same owner, it forces one idle cycle. The second is a debug spacing bit: while it is set, it forces two idle cycles after every transaction.

Top module: `sysbus_arbiter`

## Requirements
- R1: Grants are one-hot across the six lines, with `{cpu_gnt, io_gnt}` read as bit 0 = I/O 0 through bit 5 = processor 3. All grants are low during reset. `bus_idle` is high exactly when no grant is asserted.
- R2: From an idle bus after reset, a request on either I/O line or on processor 0 is granted after 3 clock edges. A request on processor 1, 2 or 3 is granted after 4 edges. No grant appears earlier.
- R3: A grant stays unchanged until an edge where `xfer_done` is high while it is asserted. Only that edge ends the transaction.
- R4: Among ordinary requesters, the fixed rank is I/O 0, then I/O 1, then processor 0, 1, 2, 3.
- R5: At a boundary, the previous owner's ordinary request ranks below every other live request. If it is the only request, the previous owner is granted again on the very next cycle with no idle cycle.
- R6: An I/O owner whose request has stayed high since its grant is granted again at every boundary. No other line is granted while it holds.
- R7: An I/O owner that lowers its request for at least one cycle during its transaction and then raises it again loses exclusivity. It competes under R5.
- R8: A processor owner that holds its request high is never exclusive. Another live requester wins the next boundary.
- R9: When the fifth consecutive back-to-back transaction of the same owner ends, exactly one idle cycle follows. The count restarts after any idle cycle and whenever a different line is granted.
- R10: When `dbg_space` is high at a boundary, exactly two idle cycles follow before the next grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 4 | Processor request lines, bit n = processor n |
| io_req | input | 2 | I/O request lines, bit n = I/O agent n |
| xfer_done | input | 1 | Current transaction ends at this edge (only meaningful while a grant is asserted) |
| dbg_space | input | 1 | Debug spacing enable: two idle cycles after every transaction |
| cpu_gnt | output | 4 | Processor grants |
| io_gnt | output | 2 | I/O grants |
| bus_idle | output | 1 | High when no agent holds the bus |

## Verification
The assertions assume three things about the inputs:
- `xfer_done` is a single-cycle strobe, and it is only meaningful while a grant is asserted.
- `dbg_space` is steady around each boundary.
- A requester that wants exclusivity keeps its line high without glitches.

The stimulus respects these assumptions. It changes inputs only at falling edges and pulses `xfer_done` for exactly one cycle while an owner is granted. Whenever a request is lowered or raised, it waits for the full request pipeline before the next boundary, so that the decision always sees the settled request picture.

// File: rtl/sba_pkg.sv
package sba_pkg;

  // Pipeline depth for one request line: the I/O lines and the first
  // processor line are fast; the remaining processor lines are slow.
  function automatic int stages_for(input int idx, input int n_io,
                                    input int fast, input int slow);
    if (idx <= n_io) return fast;
    return slow;
  endfunction

  // Idle cycles to insert after a transaction ends.
  function automatic int unsigned idle_after(input logic debug_on,
                                             input logic limit_hit,
                                             input int unsigned dbg_gap);
    int unsigned g;
    g = 0;
    if (limit_hit) g = 1;
    if (debug_on && (dbg_gap > g)) g = dbg_gap;
    return g;
  endfunction

endpackage

// File: rtl/sba_req_delay.sv
module sba_req_delay #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_out
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= (pipe << 1) | STAGES'(req_in);
  end

  assign req_out = pipe[STAGES-1];

endmodule

// File: rtl/sba_owner_select.sv
module sba_owner_select #(
  parameter int N_LINES = 6,
  parameter int N_IO    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] live_req,
  input  logic [N_LINES-1:0] last_own,
  input  logic               hold_flag,
  output logic [N_LINES-1:0] winner,
  output logic               excl
);

  localparam logic [N_LINES-1:0] IO_MASK = N_LINES'((1 << N_IO) - 1);

  // Isolate the lowest set bit, which is the highest rank.
  function automatic logic [N_LINES-1:0] lowest_one(input logic [N_LINES-1:0] v);
    return v & (~v + N_LINES'(1));
  endfunction

  logic [N_LINES-1:0] others;

  assign others = live_req & ~last_own;
  assign excl   = hold_flag && (|(live_req & last_own & IO_MASK));

  always_comb begin
    if (excl)         winner = last_own;
    else if (|others) winner = lowest_one(others);
    else              winner = lowest_one(live_req);
  end

  // R1: the choice is never more than one line
  assert_winner_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));

  // R5: a non-exclusive previous owner loses to any other live line
  assert_prev_demoted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!excl && (|others)) |-> ((winner & last_own) == '0));

endmodule

// File: rtl/sba_spacing.sv
module sba_spacing import sba_pkg::*; #(
  parameter int BURST_LIMIT = 5,
  parameter int DEBUG_GAP   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic boundary,
  input  logic debug_on,
  input  logic fire,
  input  logic same_owner,
  output logic may_arb,
  output logic limit_hit
);

  localparam int RUN_W   = $clog2(BURST_LIMIT + 1);
  localparam int GAP_W   = $clog2(DEBUG_GAP + 2);
  localparam int GAP_MAX = (DEBUG_GAP > 1) ? DEBUG_GAP : 1;

  logic [RUN_W-1:0] run_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [GAP_W-1:0] gap_need;

  assign limit_hit = (run_cnt == RUN_W'(BURST_LIMIT));
  assign gap_need  = GAP_W'(idle_after(debug_on, limit_hit, DEBUG_GAP));

  always_comb begin
    if (boundary) may_arb = (gap_need == '0);
    else          may_arb = !busy && (gap_cnt <= GAP_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      run_cnt <= '0;
    end else begin
      if (boundary)                      gap_cnt <= gap_need;
      else if (!busy && gap_cnt != '0)   gap_cnt <= gap_cnt - GAP_W'(1);

      if (fire)       run_cnt <= (boundary && same_owner) ? run_cnt + RUN_W'(1) : RUN_W'(1);
      else if (!busy) run_cnt <= '0;
    end
  end

  // R9: the back-to-back run never passes its limit
  assert_run_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(BURST_LIMIT));

  // R10: the pending gap never exceeds the longest inserted gap
  assert_gap_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= GAP_W'(GAP_MAX));

endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter import sba_pkg::*; #(
  parameter int N_CPU       = 4,
  parameter int N_IO        = 2,
  parameter int FAST_STAGES = 2,
  parameter int SLOW_STAGES = 3,
  parameter int BURST_LIMIT = 5,
  parameter int DEBUG_GAP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CPU-1:0] cpu_req,
  input  logic [N_IO-1:0]  io_req,
  input  logic             xfer_done,
  input  logic             dbg_space,
  output logic [N_CPU-1:0] cpu_gnt,
  output logic [N_IO-1:0]  io_gnt,
  output logic             bus_idle
);

  localparam int N_LINES = N_CPU + N_IO;
  localparam logic [N_LINES-1:0] IO_MASK = N_LINES'((1 << N_IO) - 1);

  logic [N_LINES-1:0] raw_req, live_req, gnt_q, last_q, winner;
  logic hold_q, excl, busy, done_evt, may_arb, fire, limit_hit, same_owner;

  assign raw_req = {cpu_req, io_req};

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    localparam int STG = stages_for(i, N_IO, FAST_STAGES, SLOW_STAGES);
    sba_req_delay #(.STAGES(STG)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (raw_req[i]),
      .req_out (live_req[i])
    );
  end

  assign busy       = |gnt_q;
  assign done_evt   = busy && xfer_done;
  assign fire       = may_arb && (|live_req);
  assign same_owner = (winner == gnt_q);

  sba_owner_select #(.N_LINES(N_LINES), .N_IO(N_IO)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_req  (live_req),
    .last_own  (last_q),
    .hold_flag (hold_q),
    .winner    (winner),
    .excl      (excl)
  );

  sba_spacing #(.BURST_LIMIT(BURST_LIMIT), .DEBUG_GAP(DEBUG_GAP)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .boundary   (done_evt),
    .debug_on   (dbg_space),
    .fire       (fire),
    .same_owner (same_owner),
    .may_arb    (may_arb),
    .limit_hit  (limit_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= '0;
      hold_q <= 1'b0;
    end else if (fire) begin
      gnt_q  <= winner;
      last_q <= winner;
      hold_q <= |(winner & IO_MASK);
    end else begin
      if (done_evt) gnt_q <= '0;
      hold_q <= hold_q && (|(live_req & last_q));
    end
  end

  assign io_gnt   = gnt_q[N_IO-1:0];
  assign cpu_gnt  = gnt_q[N_LINES-1:N_IO];
  assign bus_idle = ~busy;

  // R1: one owner at most
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R3: an owner keeps the bus until it signals the end
  assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> $stable(gnt_q));

  // R6: an exclusive I/O holder is never displaced by another line
  assert_exclusive_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && excl) |=> ((gnt_q == $past(gnt_q)) || (gnt_q == '0)));

  // R9: the boundary that ends a full run is followed by an idle cycle
  assert_burst_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && limit_hit) |=> (gnt_q == '0));

  // R10: debug spacing leaves two empty bus cycles
  assert_debug_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && dbg_space) |=> (gnt_q == '0) ##1 (gnt_q == '0));

endmodule

// File: tb/sysbus_arbiter_bench.sv
`timescale 1ns/1ps
module sysbus_arbiter_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cpu_req = '0;
  logic [1:0] io_req = '0;
  logic xfer_done = 1'b0;
  logic dbg_space = 1'b0;
  logic [3:0] cpu_gnt;
  logic [1:0] io_gnt;
  logic bus_idle;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  sysbus_arbiter u_sysbus_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .io_req(io_req),
    .xfer_done(xfer_done), .dbg_space(dbg_space),
    .cpu_gnt(cpu_gnt), .io_gnt(io_gnt), .bus_idle(bus_idle)
  );

  // grant encodings: bit0 I/O0, bit1 I/O1, bit2..5 processor 0..3
  localparam logic [5:0] G_NONE = 6'b000000;
  localparam logic [5:0] G_IO0  = 6'b000001;
  localparam logic [5:0] G_CPU0 = 6'b000100;
  localparam logic [5:0] G_CPU1 = 6'b001000;

  // {io_req, cpu_req, expected grant, edges to grant}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {2'b01, 4'b0000, 6'b000001, 4'd3},
    {2'b10, 4'b0000, 6'b000010, 4'd3},
    {2'b00, 4'b0001, 6'b000100, 4'd3},
    {2'b00, 4'b0010, 6'b001000, 4'd4},
    {2'b00, 4'b0100, 6'b010000, 4'd4},
    {2'b00, 4'b1000, 6'b100000, 4'd4},
    {2'b11, 4'b1111, 6'b000001, 4'd3},
    {2'b10, 4'b0001, 6'b000010, 4'd3},
    {2'b00, 4'b1110, 6'b001000, 4'd4},
    {2'b00, 4'b0101, 6'b000100, 4'd3}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_gnt(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {cpu_gnt, io_gnt};
    checks++;
    if (act !== exp || bus_idle !== (exp == G_NONE)) begin
      errors++;
      $display("FAIL %s: grant=%b idle=%b expected grant=%b idle=%b",
               tag, act, bus_idle, exp, (exp == G_NONE));
    end
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
  endtask

  task automatic restart(input logic [1:0] io, input logic [3:0] cpu, input logic dbg);
    rst_n = 1'b0;
    io_req = '0; cpu_req = '0; dbg_space = 1'b0; xfer_done = 1'b0;
    step(); step();
    rst_n = 1'b1; io_req = io; cpu_req = cpu; dbg_space = dbg;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    step();
    check_gnt("R1 reset", G_NONE);
    io_req = 2'b11; cpu_req = 4'b1111;
    step();
    check_gnt("R1 reset with requests", G_NONE);

    // R2 / R4: latency and rank table
    for (int v = 0; v < NV; v++) begin
      restart(VEC[v][15:14], VEC[v][13:10], 1'b0);
      for (int e = 1; e < int'(VEC[v][3:0]); e++) step();
      check_gnt($sformatf("R2 no early grant vec%0d", v), G_NONE);
      step();
      check_gnt($sformatf("R2 R4 grant vec%0d", v), VEC[v][9:4]);
    end

    // R6: I/O 0 holds while processor 0 waits; R9 idle after fifth
    restart(2'b01, 4'b0001, 1'b0);
    step(); step(); step();
    check_gnt("R4 io over cpu", G_IO0);
    for (int k = 1; k <= 4; k++) begin
      pulse_done();
      check_gnt($sformatf("R6 exclusive boundary %0d", k), G_IO0);
    end
    pulse_done();
    check_gnt("R9 idle after fifth", G_NONE);
    step();
    check_gnt("R6 regrant after idle", G_IO0);

    // R7: drop and re-raise, then processor 0 wins
    io_req = 2'b00; step(); io_req = 2'b01;
    step(); step(); step(); step();
    check_gnt("R3 grant held without done", G_IO0);
    pulse_done();
    check_gnt("R7 lost exclusivity", G_CPU0);
    cpu_req = 4'b0000;
    step(); step(); step();
    pulse_done();
    check_gnt("R5 other line granted", G_IO0);
    io_req = 2'b00; step(); io_req = 2'b01;
    step(); step(); step(); step();
    pulse_done();
    check_gnt("R5 alone regranted back-to-back", G_IO0);

    // R8: held processor requests alternate; R9 count restarts on change
    restart(2'b00, 4'b0011, 1'b0);
    step(); step(); step();
    check_gnt("R4 cpu0 first", G_CPU0);
    for (int k = 1; k <= 7; k++) begin
      pulse_done();
      check_gnt($sformatf("R8 R9 alternation %0d", k), (k % 2 == 1) ? G_CPU1 : G_CPU0);
    end

    // R9 with a lone processor: idle after fifth, count restarts after idle
    restart(2'b00, 4'b0001, 1'b0);
    step(); step(); step();
    for (int k = 1; k <= 4; k++) begin
      pulse_done();
      check_gnt($sformatf("R5 lone cpu back-to-back %0d", k), G_CPU0);
    end
    pulse_done();
    check_gnt("R9 cpu idle after fifth", G_NONE);
    step();
    check_gnt("R9 cpu regrant", G_CPU0);
    pulse_done();
    check_gnt("R9 count restarted", G_CPU0);

    // R10: debug spacing
    restart(2'b00, 4'b0001, 1'b1);
    step(); step(); step();
    check_gnt("R10 first grant", G_CPU0);
    pulse_done();
    check_gnt("R10 idle one", G_NONE);
    step();
    check_gnt("R10 idle two", G_NONE);
    step();
    check_gnt("R10 grant after gap", G_CPU0);

    finish_run();
  end

endmodule